// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a system bus and the control engines of a byte-wide flash array. It watches single-cycle bus write strobes (address and data) and picks out key-prefixed command sequences. It turns each accepted sequence into a one-clock start pulse, and the pulse carries the address and data of the final write. Seven commands are recognised: return to array read, identifier mode, byte program, whole-array erase, single-sector erase, erase pause and erase continue.

The block keeps its own record of the running embedded operation: idle, programming, whole-array erasing, sector erasing, paused, or programming while paused. It uses this record to decide which writes are obeyed and which are dropped. The program and erase engines report completion with a one-clock done strobe. While identifier mode is active, a read-side address port returns the manufacturer code, the device code or the protection flag of a sector. The storage array, the timing engines and the per-sector protect flags live outside the block.

Top module: `flash_cmd_decoder`

## Requirements
- R1: Every multi-write sequence opens with data AAh written to key address 555h, followed by data 55h written to key address 2AAh. Key addresses are matched on the low 12 address bits only; the upper bits are ignored.
- R2: After the two key writes, data A0h at 555h arms a program. The next write is taken as the target address and data, whatever its value (F0h included), and raises go_program.
- R3: After the key writes, 80h at 555h, AAh at 555h, 55h at 2AAh, a final 10h at 555h raises go_chip_erase.
- R4: The same six-write sequence ending in 30h at any address raises go_sector_erase. The target sector is the top 3 bits of the 19-bit address.
- R5: Data F0h at any address raises go_reset and abandons any partial sequence. This holds in every sequence position except the program target write.
- R6: A write with a wrong address or a wrong data value inside a sequence drops the sequence with no pulse. A fresh sequence is then decoded from its first write.
- R7: While a program or a whole-array erase runs (busy high, suspended low), every write is ignored, including the pause code B0h. The done strobe returns the block to idle.
- R8: While a sector erase runs, only B0h (any address) is obeyed. It raises go_suspend and moves the block to the paused state, in which suspended is high and busy is low.
- R9: While paused, 30h at any address raises go_resume and returns the block to sector erasing. A further 30h or B0h while erasing or paused is ignored.
- R10: While paused, a full program sequence is accepted only if its target lies outside the paused sector. While that program runs, busy and suspended are both high, and done returns the block to paused. A target inside the paused sector is dropped with no pulse. An erase sequence (80h third write) is refused.
- R11: Data 90h as the third write raises go_autosel and sets id_valid. In this mode id_data returns 1Ch at in-sector offset 0 and 04h at offset 1. At offset 2 it returns 01h or 00h, following the protect flag of the sector selected by rd_addr[18:16]. Any other offset returns 00h. Only F0h leaves the mode.
- R12: Every start pulse lasts exactly one clock and appears in the clock after the accepted write. At most one pulse is high at a time. cmd_addr and cmd_data hold the address and data of that write.
- R13: After reset the block is idle: no pulses, busy, suspended and id_valid low, and id_data zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-clock bus write strobe |
| wr_addr | input | 19 | Write address |
| wr_data | input | 8 | Write data |
| eng_done | input | 1 | One-clock completion strobe from the running engine |
| sect_prot | input | 8 | Protect flag per sector |
| rd_addr | input | 19 | Address for identifier reads |
| go_reset | output | 1 | Return-to-read pulse |
| go_autosel | output | 1 | Identifier-mode entry pulse |
| go_program | output | 1 | Byte program start pulse |
| go_chip_erase | output | 1 | Whole-array erase start pulse |
| go_sector_erase | output | 1 | Sector erase start pulse |
| go_suspend | output | 1 | Erase pause pulse |
| go_resume | output | 1 | Erase continue pulse |
| cmd_addr | output | 19 | Address of the accepted final write |
| cmd_data | output | 8 | Data of the accepted final write |
| busy | output | 1 | An embedded program or erase is running |
| suspended | output | 1 | A sector erase is paused |
| id_valid | output | 1 | Identifier mode active |
| id_data | output | 8 | Identifier byte for rd_addr |

## Verification
The assertions assume that eng_done pulses only while an operation is running, lasts one clock, and never coincides with a pause write during a sector erase. They also assume that each write strobe stands alone for a single clock. The stimulus keeps to these rules. Each write strobe is separated from the next by an idle clock. The done strobe is issued only after a start pulse has moved the block into a busy state, and never in the same clock as a write. This lets the checks on dropped writes, state moves after completion and pause-time targets stay clear of engine-ordering races.

// File: rtl/flash_cmd_pkg.sv
// Shared types and command codes for the flash command decoder.
// Assumes byte-wide data and 12-bit key address matching.
package flash_cmd_pkg;

    localparam int CMD_AW = 12;
    localparam int DATA_W = 8;

    localparam logic [CMD_AW-1:0] KEY_ADDR_A = 12'h555;
    localparam logic [CMD_AW-1:0] KEY_ADDR_B = 12'h2AA;

    localparam logic [DATA_W-1:0] C_KEY_A  = 8'hAA;
    localparam logic [DATA_W-1:0] C_KEY_B  = 8'h55;
    localparam logic [DATA_W-1:0] C_PROG   = 8'hA0;
    localparam logic [DATA_W-1:0] C_ERASE  = 8'h80;
    localparam logic [DATA_W-1:0] C_IDENT  = 8'h90;
    localparam logic [DATA_W-1:0] C_RESET  = 8'hF0;
    localparam logic [DATA_W-1:0] C_CHIP   = 8'h10;
    localparam logic [DATA_W-1:0] C_SECT   = 8'h30;
    localparam logic [DATA_W-1:0] C_PAUSE  = 8'hB0;
    localparam logic [DATA_W-1:0] C_CONT   = 8'h30;

    // Embedded operation record
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_PROG,
        OP_CHIP,
        OP_SECT,
        OP_SUSP,
        OP_SPROG
    } op_state_e;

    // Position within a key-prefixed sequence
    typedef enum logic [2:0] {
        K_IDLE,
        K_KEY1,
        K_KEY2,
        K_PTGT,
        K_ERS1,
        K_ERS2,
        K_ERS3
    } key_state_e;

    // Decoded command kinds; value minus one is the pulse bit index
    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_RESET,
        CMD_IDENT,
        CMD_PROG,
        CMD_CHIP,
        CMD_SECT,
        CMD_PAUSE,
        CMD_CONT
    } cmd_kind_e;

    localparam int NUM_CMDS = 7;

endpackage

// File: rtl/flash_key_seq.sv
// Key sequence parser. Walks the unlock-prefixed write sequences and
// decides, in the clock of the final write, which command is accepted.
// The set of accepted writes depends on the embedded operation record.
// Assumes wr_en is a single-clock strobe per bus write.
module flash_key_seq
    import flash_cmd_pkg::*;
#(
    parameter int SECT_BITS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [CMD_AW-1:0]    key_addr,
    input  logic [SECT_BITS-1:0] wr_sect,
    input  logic [DATA_W-1:0]    wr_data,
    input  op_state_e            op_state,
    input  logic                 eng_done,
    input  logic [SECT_BITS-1:0] susp_sect,
    output cmd_kind_e            cmd_kind,
    output logic                 autosel
);

    key_state_e key_q, key_d;
    logic       auto_q, auto_d;
    cmd_kind_e  cmd_d;
    logic       at_a, at_b, full_set, paused;

    assign at_a     = (key_addr == KEY_ADDR_A);
    assign at_b     = (key_addr == KEY_ADDR_B);
    assign paused   = (op_state == OP_SUSP);
    assign full_set = (op_state == OP_IDLE) || paused;

    // Next parser position, identifier flag and command decision
    always_comb begin
        key_d  = key_q;
        auto_d = auto_q;
        cmd_d  = CMD_NONE;
        if (wr_en) begin
            if (op_state == OP_SECT) begin
                if (!eng_done && wr_data == C_PAUSE) begin
                    cmd_d = CMD_PAUSE;
                end
            end else if (full_set) begin
                if (key_q != K_PTGT && wr_data == C_RESET) begin
                    cmd_d  = CMD_RESET;
                    key_d  = K_IDLE;
                    auto_d = 1'b0;
                end else begin
                    key_d = K_IDLE;
                    unique case (key_q)
                        K_IDLE: begin
                            if (paused && !auto_q && wr_data == C_CONT) begin
                                cmd_d = CMD_CONT;
                            end else if (at_a && wr_data == C_KEY_A) begin
                                key_d = K_KEY1;
                            end
                        end
                        K_KEY1: begin
                            if (at_b && wr_data == C_KEY_B) key_d = K_KEY2;
                        end
                        K_KEY2: begin
                            if (at_a && !auto_q) begin
                                if (wr_data == C_PROG) begin
                                    key_d = K_PTGT;
                                end else if (wr_data == C_ERASE && !paused) begin
                                    key_d = K_ERS1;
                                end else if (wr_data == C_IDENT) begin
                                    cmd_d  = CMD_IDENT;
                                    auto_d = 1'b1;
                                end
                            end
                        end
                        K_PTGT: begin
                            if (!(paused && wr_sect == susp_sect)) cmd_d = CMD_PROG;
                        end
                        K_ERS1: begin
                            if (at_a && wr_data == C_KEY_A) key_d = K_ERS2;
                        end
                        K_ERS2: begin
                            if (at_b && wr_data == C_KEY_B) key_d = K_ERS3;
                        end
                        K_ERS3: begin
                            if (at_a && wr_data == C_CHIP) begin
                                cmd_d = CMD_CHIP;
                            end else if (wr_data == C_SECT) begin
                                cmd_d = CMD_SECT;
                            end
                        end
                        default: key_d = K_IDLE;
                    endcase
                end
            end
        end
    end

    // Parser position and identifier-mode flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q  <= K_IDLE;
            auto_q <= 1'b0;
        end else begin
            key_q  <= key_d;
            auto_q <= auto_d;
        end
    end

    assign cmd_kind = cmd_d;
    assign autosel  = auto_q;

    // R11: the return-to-read command always clears identifier mode
    p_reset_leaves_ident_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_kind == CMD_RESET) |=> !autosel);

    // R11: identifier mode persists until a return-to-read command
    p_ident_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (autosel && cmd_kind != CMD_RESET) |=> autosel);

endmodule

// File: rtl/flash_op_tracker.sv
// Embedded operation record. Moves between idle, running, paused and
// paused-programming states on accepted commands and engine completion.
// Assumes eng_done is a one-clock strobe raised only while an operation runs.
module flash_op_tracker
    import flash_cmd_pkg::*;
#(
    parameter int SECT_BITS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  cmd_kind_e            cmd_kind,
    input  logic [SECT_BITS-1:0] wr_sect,
    input  logic                 eng_done,
    output op_state_e            op_state,
    output logic [SECT_BITS-1:0] susp_sect
);

    op_state_e            op_q, op_d;
    logic [SECT_BITS-1:0] sect_q;

    // Next operation state from command and completion
    always_comb begin
        op_d = op_q;
        unique case (op_q)
            OP_IDLE: begin
                if (cmd_kind == CMD_PROG)      op_d = OP_PROG;
                else if (cmd_kind == CMD_CHIP) op_d = OP_CHIP;
                else if (cmd_kind == CMD_SECT) op_d = OP_SECT;
            end
            OP_PROG, OP_CHIP: begin
                if (eng_done) op_d = OP_IDLE;
            end
            OP_SECT: begin
                if (eng_done)                   op_d = OP_IDLE;
                else if (cmd_kind == CMD_PAUSE) op_d = OP_SUSP;
            end
            OP_SUSP: begin
                if (cmd_kind == CMD_CONT)      op_d = OP_SECT;
                else if (cmd_kind == CMD_PROG) op_d = OP_SPROG;
            end
            OP_SPROG: begin
                if (eng_done) op_d = OP_SUSP;
            end
            default: op_d = OP_IDLE;
        endcase
    end

    // Operation state and erased-sector registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_IDLE;
            sect_q <= '0;
        end else begin
            op_q <= op_d;
            if (op_q == OP_IDLE && cmd_kind == CMD_SECT) sect_q <= wr_sect;
        end
    end

    assign op_state  = op_q;
    assign susp_sect = sect_q;

    // R7: program completion returns to idle
    p_prog_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_PROG && eng_done) |=> (op_q == OP_IDLE));

    // R9: continue from pause resumes the sector erase
    p_cont_resumes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_SUSP && cmd_kind == CMD_CONT) |=> (op_q == OP_SECT));

    // R10: paused programming completes back into the paused state
    p_sprog_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_SPROG && eng_done) |=> (op_q == OP_SUSP));

endmodule

// File: rtl/flash_id_rom.sv
// Identifier byte source. In identifier mode, returns the manufacturer
// code, device code or sector protect flag by in-sector offset.
// Assumes sect_prot is stable while it is read.
module flash_id_rom
    import flash_cmd_pkg::*;
#(
    parameter int                ADDR_W    = 19,
    parameter int                SECT_BITS = 3,
    parameter logic [DATA_W-1:0] MFR_CODE  = 8'h1C,
    parameter logic [DATA_W-1:0] DEV_CODE  = 8'h04
) (
    input  logic                        autosel,
    input  logic [ADDR_W-1:0]           rd_addr,
    input  logic [(1<<SECT_BITS)-1:0]   sect_prot,
    output logic [DATA_W-1:0]           id_data
);

    localparam int OFS_W = ADDR_W - SECT_BITS;

    logic [OFS_W-1:0]     ofs;
    logic [SECT_BITS-1:0] sect;

    assign ofs  = rd_addr[OFS_W-1:0];
    assign sect = rd_addr[ADDR_W-1 -: SECT_BITS];

    // Identifier byte selection by offset
    always_comb begin
        id_data = '0;
        if (autosel) begin
            if (ofs == OFS_W'(0))      id_data = MFR_CODE;
            else if (ofs == OFS_W'(1)) id_data = DEV_CODE;
            else if (ofs == OFS_W'(2)) id_data = {{(DATA_W-1){1'b0}}, sect_prot[sect]};
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
// Top of the flash command decoder. Joins the key parser, the operation
// record and the identifier source, and registers one-clock start pulses
// together with the address and data of the accepted write.
// Assumes single-clock write strobes and a one-clock engine done strobe.
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int          ADDR_W    = 19,
    parameter int          SECT_BITS = 3,
    parameter logic [7:0]  MFR_CODE  = 8'h1C,
    parameter logic [7:0]  DEV_CODE  = 8'h04
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [7:0]                wr_data,
    input  logic                      eng_done,
    input  logic [(1<<SECT_BITS)-1:0] sect_prot,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic                      go_reset,
    output logic                      go_autosel,
    output logic                      go_program,
    output logic                      go_chip_erase,
    output logic                      go_sector_erase,
    output logic                      go_suspend,
    output logic                      go_resume,
    output logic [ADDR_W-1:0]         cmd_addr,
    output logic [7:0]                cmd_data,
    output logic                      busy,
    output logic                      suspended,
    output logic                      id_valid,
    output logic [7:0]                id_data
);

    cmd_kind_e            cmd_kind;
    op_state_e            op_state;
    logic [SECT_BITS-1:0] wr_sect, susp_sect;
    logic                 autosel;
    logic [NUM_CMDS-1:0]  go_d, go_q;
    logic [ADDR_W-1:0]    addr_q;
    logic [DATA_W-1:0]    data_q;

    assign wr_sect = wr_addr[ADDR_W-1 -: SECT_BITS];

    flash_key_seq #(.SECT_BITS(SECT_BITS)) u_keys (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .key_addr  (wr_addr[CMD_AW-1:0]),
        .wr_sect   (wr_sect),
        .wr_data   (wr_data),
        .op_state  (op_state),
        .eng_done  (eng_done),
        .susp_sect (susp_sect),
        .cmd_kind  (cmd_kind),
        .autosel   (autosel)
    );

    flash_op_tracker #(.SECT_BITS(SECT_BITS)) u_ops (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_kind  (cmd_kind),
        .wr_sect   (wr_sect),
        .eng_done  (eng_done),
        .op_state  (op_state),
        .susp_sect (susp_sect)
    );

    flash_id_rom #(
        .ADDR_W    (ADDR_W),
        .SECT_BITS (SECT_BITS),
        .MFR_CODE  (MFR_CODE),
        .DEV_CODE  (DEV_CODE)
    ) u_ids (
        .autosel   (autosel),
        .rd_addr   (rd_addr),
        .sect_prot (sect_prot),
        .id_data   (id_data)
    );

    // One-hot pulse vector from the decided command kind
    generate
        for (genvar g = 0; g < NUM_CMDS; g++) begin : g_pulse
            assign go_d[g] = (cmd_kind == cmd_kind_e'(g + 1));
        end
    endgenerate

    // Start pulse, address and data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_q   <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            go_q <= go_d;
            if (cmd_kind != CMD_NONE) begin
                addr_q <= wr_addr;
                data_q <= wr_data;
            end
        end
    end

    assign go_reset        = go_q[0];
    assign go_autosel      = go_q[1];
    assign go_program      = go_q[2];
    assign go_chip_erase   = go_q[3];
    assign go_sector_erase = go_q[4];
    assign go_suspend      = go_q[5];
    assign go_resume       = go_q[6];
    assign cmd_addr        = addr_q;
    assign cmd_data        = data_q;

    assign busy      = (op_state == OP_PROG) || (op_state == OP_CHIP) ||
                       (op_state == OP_SECT) || (op_state == OP_SPROG);
    assign suspended = (op_state == OP_SUSP) || (op_state == OP_SPROG);
    assign id_valid  = autosel;

    // R12: never more than one start pulse at a time
    p_one_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(go_q));

    // R12: a pulse never stretches over two clocks without a new write
    p_pulse_short_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (go_q != '0 && !wr_en) |=> (go_q == '0));

    // R7: nothing is accepted while a program or whole-array erase runs
    p_busy_ignores_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_state == OP_PROG || op_state == OP_CHIP || op_state == OP_SPROG)
        |=> (go_q == '0));

    // R8: only the pause pulse can follow a running sector erase
    p_sect_only_pause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_state == OP_SECT) |=> (go_q[4:0] == '0 && !go_q[6]));

    // R10: a paused-time program never targets the paused sector
    p_sprog_outside_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (go_program && suspended) |-> (cmd_addr[ADDR_W-1 -: SECT_BITS] != susp_sect));

    // R8: a pause pulse always coincides with the paused state
    p_pause_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
        go_suspend |-> (suspended && !busy));

endmodule

// File: tb/flash_cmd_decoder_test.sv
// Table-driven bench for the flash command decoder, plus directed tests.
module flash_cmd_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n, wr_en, eng_done;
    logic [18:0] wr_addr, rd_addr, cmd_addr;
    logic [7:0]  wr_data, cmd_data, id_data, sect_prot;
    logic        go_reset, go_autosel, go_program, go_chip_erase;
    logic        go_sector_erase, go_suspend, go_resume;
    logic        busy, suspended, id_valid;
    logic [6:0]  pulses;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    flash_cmd_decoder uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .eng_done(eng_done), .sect_prot(sect_prot),
        .rd_addr(rd_addr), .go_reset(go_reset), .go_autosel(go_autosel),
        .go_program(go_program), .go_chip_erase(go_chip_erase),
        .go_sector_erase(go_sector_erase), .go_suspend(go_suspend),
        .go_resume(go_resume), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .busy(busy), .suspended(suspended), .id_valid(id_valid), .id_data(id_data)
    );

    assign pulses = {go_resume, go_suspend, go_sector_erase, go_chip_erase,
                     go_program, go_autosel, go_reset};

    // Pulse bits: 0 reset, 1 ident, 2 program, 3 chip, 4 sector, 5 pause, 6 continue
    // st bits: 0 busy, 1 suspended
    typedef struct packed {
        logic        dn;
        logic [18:0] a;
        logic [7:0]  d;
        logic [6:0]  p;
        logic [1:0]  st;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 64;
    localparam vec_t TBL [NV] = '{
        // R2 program, F0h as target data
        '{1'b0, 19'h00555, 8'hAA, 7'h00, 2'b00, 4'd2},
        '{1'b0, 19'h002AA, 8'h55, 7'h00, 2'b00, 4'd2},
        '{1'b0, 19'h00555, 8'hA0, 7'h00, 2'b00, 4'd2},
        '{1'b0, 19'h12345, 8'hF0, 7'h04, 2'b01, 4'd2},
        // R7 writes ignored while programming, done returns to idle
        '{1'b0, 19'h00555, 8'hAA, 7'h00, 2'b01, 4'd7},
        '{1'b0, 19'h00555, 8'hF0, 7'h00, 2'b01, 4'd7},
        '{1'b1, 19'h00000, 8'h00, 7'h00, 2'b00, 4'd7},
        // R3 whole-array erase
        '{1'b0, 19'h00555, 8'hAA, 7'h00, 2'b00, 4'd3},
        '{1'b0, 19'h002AA, 8'h55, 7'h00, 2'b00, 4'd3},
        '{1'b0, 19'h00555, 8'h80, 7'h00, 2'b00, 4'd3},
        '{1'b0, 19'h00555, 8'hAA, 7'h00, 2'b00, 4'd3},
        '{1'b0, 19'h002AA, 8'h55, 7'h00, 2'b00, 4'd3},
        '{1'b0, 19'h00555, 8'h10, 7'h08, 2'b01, 4'd3},
        // R7 pause ignored during whole-array erase
        '{1'b0, 19'h00000, 8'hB0, 7'h00, 2'b01, 4'd7},
        '{1'b1, 19'h00000, 8'h00, 7'h00, 2'b00, 4'd7},
        // R4 sector erase of sector 3
        '{1'b0, 19'h00555, 8'hAA, 7'h00, 2'b00, 4'd4},
        '{1'b0, 19'h002AA, 8'h55, 7'h00, 2'b00, 4'd4},
        '{1'b0, 19'h00555, 8'h80, 7'h00, 2'b00, 4'd4},
        '{1'b0, 19'h00555, 8'hAA, 7'h00, 2'b00, 4'd4},
        '{1'b0, 19'h002AA, 8'h55, 7'h00, 2'b00, 4'd4},
        '{1'b0, 19'h3ABCD, 8'h30, 7'h10, 2'b01, 4'd4},
        // R8 only pause obeyed during sector erase
        '{1'b0, 19'h00555, 8'hF0, 7'h00, 2'b01, 4'd8},
        '{1'b0, 19'h00000, 8'h30, 7'h00, 2'b01, 4'd8},
        '{1'b0, 19'h00000, 8'hB0, 7'h20, 2'b10, 4'd8},
        // R9 second pause ignored
        '{1'b0, 19'h00000, 8'hB0, 7'h00, 2'b10, 4'd9},
        // R10 program inside the paused sector dropped
        '{1'b0, 19'h00555, 8'hAA, 7'h00, 2'b10, 4'd10},
        '{1'b0, 19'h002AA, 8'h55, 7'h00, 2'b10, 4'd10},
        '{1'b0, 19'h00555, 8'hA0, 7'h00, 2'b10, 4'd10},
        '{1'b0, 19'h30000, 8'h11, 7'h00, 2'b10, 4'd10},
        // R10 program outside the paused sector accepted
        '{1'b0, 19'h00555, 8'hAA, 7'h00, 2'b10, 4'd10},
        '{1'b0, 19'h002AA, 8'h55, 7'h00, 2'b10, 4'd10},
        '{1'b0, 19'h00555, 8'hA0, 7'h00, 2'b10, 4'd10},
        '{1'b0, 19'h50000, 8'h22, 7'h04, 2'b11, 4'd10},
        '{1'b1, 19'h00000, 8'h00, 7'h00, 2'b10, 4'd10},
        // R10 erase setup refused while paused
        '{1'b0, 19'h00555, 8'hAA, 7'h00, 2'b10, 4'd10},
        '{1'b0, 19'h002AA, 8'h55, 7'h00, 2'b10, 4'd10},
        '{1'b0, 19'h00555, 8'h80, 7'h00, 2'b10, 4'd10},
        // R9 continue, then repeated continue ignored
        '{1'b0, 19'h00000, 8'h30, 7'h40, 2'b01, 4'd9},
        '{1'b0, 19'h00000, 8'h30, 7'h00, 2'b01, 4'd9},
        '{1'b1, 19'h00000, 8'h00, 7'h00, 2'b00, 4'd9},
        // R5 reset mid-sequence
        '{1'b0, 19'h00555, 8'hAA, 7'h00, 2'b00, 4'd5},
        '{1'b0, 19'h002AA, 8'h55, 7'h00, 2'b00, 4'd5},
        '{1'b0, 19'h00555, 8'hF0, 7'h01, 2'b00, 4'd5},
        '{1'b0, 19'h00555, 8'hAA, 7'h00, 2'b00, 4'd5},
        '{1'b0, 19'h07777, 8'hF0, 7'h01, 2'b00, 4'd5},
        // R6 broken sequences then a clean one
        '{1'b0, 19'h00554, 8'hAA, 7'h00, 2'b00, 4'd6},
        '{1'b0, 19'h00555, 8'hAA, 7'h00, 2'b00, 4'd6},
        '{1'b0, 19'h002AB, 8'h55, 7'h00, 2'b00, 4'd6},
        '{1'b0, 19'h00555, 8'hAA, 7'h00, 2'b00, 4'd6},
        '{1'b0, 19'h002AA, 8'h55, 7'h00, 2'b00, 4'd6},
        '{1'b0, 19'h00555, 8'h77, 7'h00, 2'b00, 4'd6},
        '{1'b0, 19'h00555, 8'hAA, 7'h00, 2'b00, 4'd6},
        '{1'b0, 19'h002AA, 8'h55, 7'h00, 2'b00, 4'd6},
        '{1'b0, 19'h00555, 8'hA0, 7'h00, 2'b00, 4'd6},
        '{1'b0, 19'h00100, 8'h5A, 7'h04, 2'b01, 4'd6},
        '{1'b1, 19'h00000, 8'h00, 7'h00, 2'b00, 4'd6},
        // R1 upper address bits ignored in key matching
        '{1'b0, 19'h7F555, 8'hAA, 7'h00, 2'b00, 4'd1},
        '{1'b0, 19'h1A2AA, 8'h55, 7'h00, 2'b00, 4'd1},
        '{1'b0, 19'h33555, 8'hA0, 7'h00, 2'b00, 4'd1},
        '{1'b0, 19'h00001, 8'h01, 7'h04, 2'b01, 4'd1},
        '{1'b1, 19'h00000, 8'h00, 7'h00, 2'b00, 4'd1},
        // R11 identifier mode entry
        '{1'b0, 19'h00555, 8'hAA, 7'h00, 2'b00, 4'd11},
        '{1'b0, 19'h002AA, 8'h55, 7'h00, 2'b00, 4'd11},
        '{1'b0, 19'h00555, 8'h90, 7'h02, 2'b00, 4'd11}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [18:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic id_rd(input string req, input logic [18:0] a, input logic [7:0] exp);
        @(negedge clk);
        rd_addr = a;
        #1;
        chk(req, {24'h0, id_data}, {24'h0, exp});
    endtask

    // Watchdog ends a hung run as a failure
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; eng_done = 1'b0;
        wr_addr = '0; wr_data = '0; rd_addr = '0; sect_prot = 8'b0010_0100;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk("R13 pulses", {25'h0, pulses}, 32'h0);
        chk("R13 busy/suspended", {30'h0, suspended, busy}, 32'h0);
        chk("R13 id_valid", {31'h0, id_valid}, 32'h0);
        chk("R13 id_data", {24'h0, id_data}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            if (TBL[i].dn) eng_done = 1'b1;
            else begin
                wr_en = 1'b1; wr_addr = TBL[i].a; wr_data = TBL[i].d;
            end
            @(negedge clk);
            wr_en = 1'b0; eng_done = 1'b0;
            chk($sformatf("R%0d row %0d pulses", TBL[i].rq, i), {25'h0, pulses}, {25'h0, TBL[i].p});
            chk($sformatf("R%0d row %0d state", TBL[i].rq, i), {30'h0, suspended, busy}, {30'h0, TBL[i].st});
            if (TBL[i].p != '0) begin
                // R12 captured address and data of the final write
                chk($sformatf("R12 row %0d cmd_addr", i), {13'h0, cmd_addr}, {13'h0, TBL[i].a});
                chk($sformatf("R12 row %0d cmd_data", i), {24'h0, cmd_data}, {24'h0, TBL[i].d});
                @(negedge clk);
                chk($sformatf("R12 row %0d pulse one clock", i), {25'h0, pulses}, 32'h0);
            end
        end

        // R11 identifier reads
        #1;
        chk("R11 id_valid set", {31'h0, id_valid}, 32'h1);
        id_rd("R11 manufacturer code", 19'h00000, 8'h1C);
        id_rd("R11 device code", 19'h00001, 8'h04);
        id_rd("R11 protected sector 2", 19'h20002, 8'h01);
        id_rd("R11 unprotected sector 3", 19'h30002, 8'h00);
        id_rd("R11 protected sector 5", 19'h50002, 8'h01);
        id_rd("R11 other offset", 19'h00003, 8'h00);
        id_rd("R11 high offset", 19'h00102, 8'h00);
        // R11 broken writes keep identifier mode
        bus_wr(19'h00555, 8'hAA);
        bus_wr(19'h002AA, 8'h11);
        chk("R11 mode kept after broken write", {31'h0, id_valid}, 32'h1);
        bus_wr(19'h00555, 8'hAA);
        bus_wr(19'h002AA, 8'h55);
        bus_wr(19'h00555, 8'hA0);
        chk("R11 program refused in id mode", {25'h0, pulses}, 32'h0);
        bus_wr(19'h00000, 8'hF0);
        chk("R11 reset pulse", {25'h0, pulses}, 32'h01);
        chk("R11 mode left", {31'h0, id_valid}, 32'h0);
        id_rd("R11 id_data cleared", 19'h00000, 8'h00);

        // R5 reset while paused keeps the pause
        bus_wr(19'h00555, 8'hAA); bus_wr(19'h002AA, 8'h55); bus_wr(19'h00555, 8'h80);
        bus_wr(19'h00555, 8'hAA); bus_wr(19'h002AA, 8'h55); bus_wr(19'h10000, 8'h30);
        bus_wr(19'h00000, 8'hB0);
        chk("R8 paused state", {30'h0, suspended, busy}, 32'h2);
        bus_wr(19'h00000, 8'hF0);
        chk("R5 reset while paused", {25'h0, pulses}, 32'h01);
        chk("R5 pause kept", {30'h0, suspended, busy}, 32'h2);

        // R13 reset during an operation returns to idle
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R13 reset clears operation", {30'h0, suspended, busy}, 32'h0);
        chk("R13 reset clears pulses", {25'h0, pulses}, 32'h0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule